// File: doc/BRIEF.md
# SDRAM Power-Up Command Issuer

This block sits between a processor bus and an SDR-SDRAM device while the memory is being brought up. Software writes a three-bit mode code into a small register. It then performs an ordinary write into the SDRAM address window. That write does not move data. It makes the block place exactly one SDRAM command on the device pins, wait out the recovery time of that command, and then acknowledge the bus access. Software walks the device through its start-up flow this way, one access per command: NOP, precharge-all, a series of auto-refreshes, then the mode and extended-mode loads, and finally normal mode.

A parameterised power-up counter holds every SDRAM pin at its reset value and stalls every access until the required pause has elapsed. A status output reports when the pause is over. The clock enable stays low until the first NOP command is issued, and then stays high. For the two mode-load commands, the bank pins and the address pins are taken from the access address. The device is assumed to be 16 bits wide with 9 column bits, 12 row bits and 4 banks, so the bank field sits at offset bits [23:22] and the mode value at bits [12:1]. Normal data bursts are not part of this block; a normal access is simply acknowledged.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: Reset state:
  - `sdram_cke_o` is 0.
  - The command pins {cs_n,ras_n,cas_n,we_n} are 4'b0111 (NOP).
  - `sdram_ba_o` and `sdram_a_o` are 0.
  - `mem_ready_o` is 0, `pwr_done_o` is 0 and `mode_o` is 0.
- R2: `pwr_done_o` first reads 1 after exactly PWRUP_CYC rising clock edges following reset release. Until then:
  - every access is stalled (`mem_ready_o` stays 0);
  - `sdram_cke_o` stays 0;
  - the command pins stay at NOP.
- R3: A write access issues a command that depends on `mode_o`, given as {cs_n,ras_n,cas_n,we_n}:
  - mode 1 issues NOP, 4'b0111.
  - mode 2 issues precharge-all, 4'b0010, with A[10]=1 and every other A bit 0 and BA=0.
  - mode 4 issues auto-refresh, 4'b0001, with A=0 and BA=0.
  - modes 3 and 5 issue a mode-register load, 4'b0000.
- R4: Each write access in modes 1 to 5 drives its command for exactly one clock cycle. The pins return to NOP afterwards.
- R5: A command-issuing access is acknowledged by a one-cycle `mem_ready_o` pulse L+2 rising edges after the first edge that samples the request. L depends on the command:
  - L=0 for NOP;
  - L=T_RP for precharge-all;
  - L=T_RFC for auto-refresh;
  - L=T_MRD for the mode-register loads.
- R6: `sdram_cke_o` rises in the same cycle as the first issued NOP command and never falls afterwards.
- R7: For modes 3 and 5:
  - `sdram_ba_o` equals address bits [23:22] (bank 2'b00 at offset 0x000000, bank 2'b10 at offset 0x800000);
  - `sdram_a_o` equals address bits [12:1].
- R8: The following accesses issue no command and are acknowledged by a one-cycle `mem_ready_o` pulse one edge after the request is sampled:
  - a read, in any mode;
  - any access in mode 0;
  - any access in the unused modes 6 and 7.
- R9: The mode register may be written only while `cfg_ready_o` is 1. `cfg_ready_o` is 0 from the edge that accepts an access until that access completes. A write attempted while `cfg_ready_o` is 0 leaves `mode_o` unchanged.
- R10: Successive write accesses in mode 4 issue one auto-refresh each, so eight writes yield exactly eight refresh commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_mode_i | input | 3 | Mode code to write |
| cfg_ready_o | output | 1 | Mode register write is accepted this cycle |
| mode_o | output | 3 | Current mode code |
| pwr_done_o | output | 1 | Power-up pause has elapsed |
| mem_req_i | input | 1 | Access request into the SDRAM window, held until acknowledged |
| mem_we_i | input | 1 | Access is a write |
| mem_addr_i | input | 24 | Byte offset inside the SDRAM window |
| mem_ready_o | output | 1 | One-cycle access acknowledge |
| sdram_cke_o | output | 1 | SDRAM clock enable |
| sdram_cs_no | output | 1 | SDRAM chip select, active low |
| sdram_ras_no | output | 1 | SDRAM row strobe, active low |
| sdram_cas_no | output | 1 | SDRAM column strobe, active low |
| sdram_we_no | output | 1 | SDRAM write enable, active low |
| sdram_ba_o | output | 2 | SDRAM bank address |
| sdram_a_o | output | 12 | SDRAM address pins |

## Verification
- **Command timing.** Each command appears on the pins in the cycle after the first edge that samples the request. The acknowledge follows L+1 edges later, or one edge after the request when no command is issued.
- **How the bench samples.** The bench drives inputs and samples outputs at falling edges. It counts rising edges from the request up to the acknowledge and compares that count with L+2 or 1, computed from the mode.
- **Pins and configuration state.** Pin snapshots are taken at every falling edge of the access, so a command that lasts more than one cycle, or a second command, is counted. `cfg_ready_o` is checked at each of those same samples.
- **Power-up pause.** The edges since reset release are counted independently of the design and compared with PWRUP_CYC.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_NOP    = 3'd1;
  localparam logic [2:0] MODE_PALL   = 3'd2;
  localparam logic [2:0] MODE_LMR    = 3'd3;
  localparam logic [2:0] MODE_REF    = 3'd4;
  localparam logic [2:0] MODE_ELMR   = 3'd5;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam cmd_pins_t PINS_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam cmd_pins_t PINS_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam cmd_pins_t PINS_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

  typedef enum logic [1:0] {LAT_NONE, LAT_RP, LAT_RFC, LAT_MRD} lat_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_ACK} issue_st_e;
endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
  parameter int unsigned PWRUP_CYC = 10000,
  localparam int unsigned CW = $clog2(PWRUP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CW'(PWRUP_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned BA_W     = 2,
  parameter int unsigned A_W      = 12,
  parameter int unsigned BANK_LSB = 22,
  parameter int unsigned MR_LSB   = 1,
  parameter int unsigned AP_BIT   = 10
) (
  input  logic [2:0]        mode_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              issue_o,
  output logic              is_nop_o,
  output cmd_pins_t         pins_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [A_W-1:0]    a_o,
  output lat_sel_e          lat_o
);
  always_comb begin
    issue_o  = 1'b0;
    is_nop_o = 1'b0;
    pins_o   = PINS_NOP;
    ba_o     = '0;
    a_o      = '0;
    lat_o    = LAT_NONE;
    if (we_i) begin
      unique case (mode_i)
        MODE_NOP: begin
          issue_o  = 1'b1;
          is_nop_o = 1'b1;
        end
        MODE_PALL: begin
          issue_o     = 1'b1;
          pins_o      = PINS_PALL;
          a_o[AP_BIT] = 1'b1;
          lat_o       = LAT_RP;
        end
        MODE_REF: begin
          issue_o = 1'b1;
          pins_o  = PINS_REF;
          lat_o   = LAT_RFC;
        end
        MODE_LMR, MODE_ELMR: begin
          issue_o = 1'b1;
          pins_o  = PINS_LMR;
          ba_o    = addr_i[BANK_LSB +: BA_W];
          a_o     = addr_i[MR_LSB +: A_W];
          lat_o   = LAT_MRD;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sdram_issue_ctrl.sv
module sdram_issue_ctrl
  import sdram_init_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned A_W   = 12,
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RFC = 6,
  parameter int unsigned T_MRD = 2,
  localparam int unsigned T_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                                 : ((T_RP > T_MRD) ? T_RP : T_MRD),
  localparam int unsigned LW = $clog2(T_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_done_i,
  input  logic            req_i,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_mode_i,
  input  logic            issue_i,
  input  logic            is_nop_i,
  input  cmd_pins_t       dec_pins_i,
  input  logic [BA_W-1:0] dec_ba_i,
  input  logic [A_W-1:0]  dec_a_i,
  input  lat_sel_e        lat_i,
  output logic [2:0]      mode_o,
  output logic            cfg_ready_o,
  output logic            ready_o,
  output logic            cke_o,
  output cmd_pins_t       pins_o,
  output logic [BA_W-1:0] ba_o,
  output logic [A_W-1:0]  a_o
);
  issue_st_e      st_q;
  logic [LW-1:0]  cnt_q;
  logic [LW-1:0]  lat_cnt;

  always_comb begin
    unique case (lat_i)
      LAT_RP:  lat_cnt = LW'(T_RP);
      LAT_RFC: lat_cnt = LW'(T_RFC);
      LAT_MRD: lat_cnt = LW'(T_MRD);
      default: lat_cnt = '0;
    endcase
  end

  assign cfg_ready_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      mode_o  <= MODE_NORMAL;
      ready_o <= 1'b0;
      cke_o   <= 1'b0;
      pins_o  <= PINS_NOP;
      ba_o    <= '0;
      a_o     <= '0;
    end else begin
      pins_o  <= PINS_NOP;
      ba_o    <= '0;
      a_o     <= '0;
      ready_o <= 1'b0;
      if (cfg_we_i && st_q == ST_IDLE) mode_o <= cfg_mode_i;
      unique case (st_q)
        ST_IDLE: begin
          if (pwr_done_i && req_i) begin
            if (issue_i) begin
              pins_o <= dec_pins_i;
              ba_o   <= dec_ba_i;
              a_o    <= dec_a_i;
              cnt_q  <= lat_cnt;
              st_q   <= ST_HOLD;
              if (is_nop_i) cke_o <= 1'b1;
            end else begin
              ready_o <= 1'b1;
              st_q    <= ST_ACK;
            end
          end
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            ready_o <= 1'b1;
            st_q    <= ST_ACK;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned A_W       = 12,
  parameter int unsigned BANK_LSB  = 22,
  parameter int unsigned MR_LSB    = 1,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned PWRUP_CYC = 10000,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RFC     = 6,
  parameter int unsigned T_MRD     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_mode_i,
  output logic              cfg_ready_o,
  output logic [2:0]        mode_o,
  output logic              pwr_done_o,
  input  logic              mem_req_i,
  input  logic              mem_we_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  output logic              mem_ready_o,
  output logic              sdram_cke_o,
  output logic              sdram_cs_no,
  output logic              sdram_ras_no,
  output logic              sdram_cas_no,
  output logic              sdram_we_no,
  output logic [BA_W-1:0]   sdram_ba_o,
  output logic [A_W-1:0]    sdram_a_o
);
  logic            issue, is_nop;
  cmd_pins_t       dec_pins, pins;
  logic [BA_W-1:0] dec_ba;
  logic [A_W-1:0]  dec_a;
  lat_sel_e        lat_sel;

  sdram_pwrup_timer #(.PWRUP_CYC(PWRUP_CYC)) i_timer (
    .clk_i, .rst_ni, .done_o(pwr_done_o)
  );

  sdram_cmd_decode #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .A_W(A_W),
    .BANK_LSB(BANK_LSB), .MR_LSB(MR_LSB), .AP_BIT(AP_BIT)
  ) i_decode (
    .mode_i(mode_o), .we_i(mem_we_i), .addr_i(mem_addr_i),
    .issue_o(issue), .is_nop_o(is_nop), .pins_o(dec_pins),
    .ba_o(dec_ba), .a_o(dec_a), .lat_o(lat_sel)
  );

  sdram_issue_ctrl #(
    .BA_W(BA_W), .A_W(A_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) i_ctrl (
    .clk_i, .rst_ni,
    .pwr_done_i(pwr_done_o), .req_i(mem_req_i),
    .cfg_we_i, .cfg_mode_i,
    .issue_i(issue), .is_nop_i(is_nop), .dec_pins_i(dec_pins),
    .dec_ba_i(dec_ba), .dec_a_i(dec_a), .lat_i(lat_sel),
    .mode_o, .cfg_ready_o, .ready_o(mem_ready_o), .cke_o(sdram_cke_o),
    .pins_o(pins), .ba_o(sdram_ba_o), .a_o(sdram_a_o)
  );

  assign sdram_cs_no  = pins.cs_n;
  assign sdram_ras_no = pins.ras_n;
  assign sdram_cas_no = pins.cas_n;
  assign sdram_we_no  = pins.we_n;
endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk #(
  parameter int unsigned BA_W   = 2,
  parameter int unsigned A_W    = 12,
  parameter int unsigned AP_BIT = 10
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cfg_ready_o,
  input logic            pwr_done_o,
  input logic            mem_ready_o,
  input logic            sdram_cke_o,
  input logic            sdram_cs_no,
  input logic            sdram_ras_no,
  input logic            sdram_cas_no,
  input logic            sdram_we_no,
  input logic [BA_W-1:0] sdram_ba_o,
  input logic [A_W-1:0]  sdram_a_o
);
  logic [3:0] pins;
  assign pins = {sdram_cs_no, sdram_ras_no, sdram_cas_no, sdram_we_no};

  // R2
  pwrup_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done_o |-> (!mem_ready_o && !sdram_cke_o && pins == 4'b0111));

  // R2
  pwrup_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_done_o |=> pwr_done_o);

  // R4
  cmd_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != 4'b0111) |=> (pins == 4'b0111));

  // R5
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ready_o |=> !mem_ready_o);

  // R6
  cke_no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sdram_cke_o));

  // R9
  cfg_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != 4'b0111 || mem_ready_o) |-> !cfg_ready_o);

  // R3
  pall_ap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010) |-> (sdram_a_o[AP_BIT] && sdram_ba_o == '0));
endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk #(
  .BA_W(BA_W), .A_W(A_W), .AP_BIT(AP_BIT)
) i_chk (
  .clk_i, .rst_ni, .cfg_ready_o, .pwr_done_o, .mem_ready_o, .sdram_cke_o,
  .sdram_cs_no, .sdram_ras_no, .sdram_cas_no, .sdram_we_no, .sdram_ba_o, .sdram_a_o
);

// File: tb/test_sdram_cmd_issuer.sv
module test_sdram_cmd_issuer;
  localparam int PWR = 400;
  localparam int TRP = 2, TRFC = 5, TMRD = 3;
  localparam logic [3:0] NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_ready;
  logic [2:0] cfg_mode = '0, mode;
  logic pwr_done, req = 1'b0, we = 1'b0, ready, cke;
  logic [23:0] addr = '0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] a;
  logic [3:0] pins;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  assign pins = {cs_n, ras_n, cas_n, we_n};

  always #10 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  sdram_cmd_issuer #(.PWRUP_CYC(PWR), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) i_sdram_cmd_issuer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_ready_o(cfg_ready), .mode_o(mode), .pwr_done_o(pwr_done),
    .mem_req_i(req), .mem_we_i(we), .mem_addr_i(addr), .mem_ready_o(ready),
    .sdram_cke_o(cke), .sdram_cs_no(cs_n), .sdram_ras_no(ras_n), .sdram_cas_no(cas_n),
    .sdram_we_no(we_n), .sdram_ba_o(ba), .sdram_a_o(a)
  );

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_pins(input logic [2:0] m, input logic w);
    if (!w) return NOP;
    case (m)
      3'd1: return NOP;
      3'd2: return 4'b0010;
      3'd4: return 4'b0001;
      3'd3, 3'd5: return 4'b0000;
      default: return NOP;
    endcase
  endfunction

  function automatic bit exp_issue(input logic [2:0] m, input logic w);
    return w && m >= 3'd1 && m <= 3'd5;
  endfunction

  function automatic int exp_edges(input logic [2:0] m, input logic w);
    if (!exp_issue(m, w)) return 1;
    case (m)
      3'd2: return TRP + 2;
      3'd4: return TRFC + 2;
      3'd3, 3'd5: return TMRD + 2;
      default: return 2;
    endcase
  endfunction

  function automatic logic [13:0] exp_ba_a(input logic [2:0] m, input logic [23:0] ad);
    if (m == 3'd3 || m == 3'd5) return {ad[23:22], ad[12:1]};
    if (m == 3'd2) return {2'b00, 12'h400};
    return '0;
  endfunction

  task automatic cfg_write(input logic [2:0] m);
    cfg_we = 1'b1; cfg_mode = m;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic w, input logic [23:0] ad, output int edges, output int ncmd,
                        output logic [3:0] cmd, output logic [13:0] baa, output bit busy_ok);
    req = 1'b1; we = w; addr = ad;
    edges = 0; ncmd = 0; cmd = NOP; baa = '0; busy_ok = 1'b1;
    do begin
      @(posedge clk); edges++; @(negedge clk);
      if (pins != NOP) begin ncmd++; cmd = pins; baa = {ba, a}; end
      if (!ready && cfg_ready) busy_ok = 1'b0;
    end while (!ready && edges < 1000);
    req = 1'b0;
    @(negedge clk);
    chk(!ready, "R5", "ready pulse width", ready, 0);
  endtask

  task automatic run_one(input logic [2:0] m, input logic w, input logic [23:0] ad, input string tag);
    int edges, ncmd;
    logic [3:0] cmd;
    logic [13:0] baa;
    bit busy_ok;
    access(w, ad, edges, ncmd, cmd, baa, busy_ok);
    chk(edges == exp_edges(m, w), exp_issue(m, w) ? "R5" : "R8", {tag, " ack edges"}, edges, exp_edges(m, w));
    if (exp_issue(m, w) && m != 3'd1) begin
      chk(ncmd == 1, "R4", {tag, " command count"}, ncmd, 1);
      chk(cmd == exp_pins(m, w), "R3", {tag, " command pins"}, cmd, exp_pins(m, w));
      chk(baa == exp_ba_a(m, ad), (m == 3'd2) ? "R3" : "R7", {tag, " ba/a"}, baa, exp_ba_a(m, ad));
    end else if (!exp_issue(m, w)) begin
      chk(ncmd == 0, "R8", {tag, " no command"}, ncmd, 0);
    end
    chk(busy_ok, "R9", {tag, " cfg_ready low while busy"}, busy_ok, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int edges, ncmd, nref;
    logic [3:0] cmd;
    logic [13:0] baa;
    bit busy_ok;
    void'($urandom(32'h5d2a));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cke == 0 && pins == NOP && ba == 0 && a == 0, "R1", "pins in reset", {cke, pins, ba, a}, {1'b0, NOP, 14'h0});
    chk(!ready && !pwr_done && mode == 0, "R1", "status in reset", {ready, pwr_done, mode}, 0);
    rst_n = 1'b1;
    cfg_write(3'd1);
    chk(mode == 3'd1, "R9", "mode written while idle", mode, 1);
    req = 1'b1; we = 1'b1; addr = '0;
    while (!pwr_done) begin
      @(posedge clk); @(negedge clk);
      if (!pwr_done && (ready || cke || pins != NOP)) begin
        chk(0, "R2", "activity during pause", {ready, cke, pins}, {2'b00, NOP});
        break;
      end
    end
    chk(cyc == PWR, "R2", "pause length", cyc, PWR);
    access(1'b1, 24'h0, edges, ncmd, cmd, baa, busy_ok);
    chk(edges == 2, "R5", "NOP ack edges", edges, 2);
    chk(cke == 1'b1, "R6", "cke high after NOP", cke, 1);
    // R6 cke stays high; R8 read in nonzero mode
    run_one(3'd1, 1'b0, 24'h123456, "read mode1");
    chk(cke == 1'b1, "R6", "cke still high", cke, 1);
    cfg_write(3'd2); run_one(3'd2, 1'b1, 24'h3abcde, "precharge");
    // R10 eight refreshes
    cfg_write(3'd4);
    nref = 0;
    for (int i = 0; i < 8; i++) begin
      access(1'b1, 24'(i * 2), edges, ncmd, cmd, baa, busy_ok);
      if (cmd == 4'b0001) nref += ncmd;
    end
    chk(nref == 8, "R10", "refresh count", nref, 8);
    // R9 held-off write during refresh
    req = 1'b1; we = 1'b1; addr = '0;
    @(posedge clk); @(negedge clk);
    chk(!cfg_ready, "R9", "cfg_ready low in flight", cfg_ready, 0);
    cfg_we = 1'b1; cfg_mode = 3'd0;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
    while (!ready) begin @(posedge clk); @(negedge clk); end
    req = 1'b0;
    @(negedge clk);
    chk(mode == 3'd4, "R9", "mode unchanged by held-off write", mode, 4);
    // R7 mode loads
    cfg_write(3'd3); run_one(3'd3, 1'b1, 24'h000046, "MRS bank0");
    cfg_write(3'd5); run_one(3'd5, 1'b1, 24'h800000, "EMRS bank2");
    cfg_write(3'd0); run_one(3'd0, 1'b1, 24'h000010, "normal");
    cfg_write(3'd6); run_one(3'd6, 1'b1, 24'h000010, "reserved6");
    cfg_write(3'd7); run_one(3'd7, 1'b1, 24'h000010, "reserved7");
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [2:0] m;
      logic w;
      logic [23:0] ad;
      m = 3'($urandom_range(0, 7));
      w = 1'($urandom_range(0, 1));
      ad = 24'($urandom);
      cfg_write(m);
      chk(mode == m, "R9", "random mode write", mode, m);
      run_one(m, w, ad, "random");
    end
    chk(cke == 1'b1, "R6", "cke never fell", cke, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule